// File: doc/BRIEF.md
# Serial-Loaded DAC Code Register Front End

This block is the digital side of a 16-bit voltage-output converter. A host writes a code over a framed three-wire serial port. The port has an active-low frame/enable line, a serial clock and a data line. Each falling serial-clock edge inside a frame shifts one data bit into a shift register, most significant bit first. When a frame closes after at least a full word of edges, the last 16 bits move into a holding (input) register. A separate active-low load line then moves the held word into the code register that drives the converter. The code uses straight binary: 0x0000 selects the most negative output and 0xFFFF selects full scale minus one step.

The load line chooses between two update modes. If the load line is already low when the frame closes, the code register takes the new word on that frame-closing edge (synchronous mode). If the load line is low while no frame is open, the code register copies the holding register (asynchronous mode). The bit leaving the top of the shift register is driven out, so several parts can be chained on one frame. A power-down input is passed through as a flag for the analog section.

All serial pins are oversampled by a system clock through a synchronizer. An edge on a pin therefore acts on the outputs a fixed few cycles later. The shift register, the holding register and the code register all start at midscale.

Top module: `sdac_load_if`

## Requirements
- R1: After reset, dac_code is 0x8000, ser_out is 1 (the top bit of the midscale shift register) and dac_off is 0.
- R2: A falling edge of ser_clk shifts ser_din into bit 0 of the shift register only while frame_n is low, with earlier bits moving toward bit 15. ser_out always shows bit 15. Falling edges while frame_n is high shift nothing.
- R3: When frame_n rises after 16 or more falling edges in the frame, the last 16 bits shifted become the holding-register word. All codes from 0x0000 to 0xFFFF are carried unchanged.
- R4: When frame_n rises after fewer than 16 falling edges, including none, the holding register keeps its previous word.
- R5: While frame_n is high and load_n is low, dac_code is updated with the holding-register word.
- R6: When load_n is low at the moment frame_n rises after a full frame, dac_code takes the new word at that same update.
- R7: While load_n is high, dac_code does not change, even when a full frame completes.
- R8: In a frame longer than 16 edges, ser_out presents, after shift k (k of 16 or more), the bit shifted in at shift k-15. A subsequent load yields the final 16 bits.
- R9: dac_off follows pwr_dn after the synchronizer latency. It does not alter dac_code or the serial path.
- R10: Every pin reaches the outputs through SYNC_STAGES synchronizer flops plus one register stage (3 cycles with defaults).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| frame_n | input | 1 | Active-low frame and enable for the serial port |
| ser_clk | input | 1 | Serial clock; data is taken on its falling edge |
| ser_din | input | 1 | Serial data, most significant bit first |
| load_n | input | 1 | Active-low transfer of holding register to code register |
| pwr_dn | input | 1 | Power-down request for the analog section |
| ser_out | output | 1 | Top bit of the shift register, for daisy chaining |
| dac_code | output | 16 | Straight-binary converter code |
| dac_off | output | 1 | Synchronized power-down flag |

## Verification
The case that is hardest to reach from the ports is the chained frame. The serial output must carry the first word while the second is still arriving, and the partial-frame discard must hold the holding register across an unrelated load. The stimulus reaches both by running a 32-edge frame in two parts and sampling ser_out between them, by closing frames after 10 edges and after none, and by pulsing load_n before any new full frame. A behavioural model fed the same pin history (a queue delayed by the synchronizer depth) is compared against all three outputs on every clock. Directed value checks cover the midscale start, the code extremes and the two update modes.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int unsigned PIN_CNT = 5;
  // Pin vector order used by the synchronizer
  localparam int unsigned P_FRAME = 0;
  localparam int unsigned P_SCK   = 1;
  localparam int unsigned P_DIN   = 2;
  localparam int unsigned P_LOAD  = 3;
  localparam int unsigned P_PD    = 4;
  // Idle levels: frame high, load high, others low
  localparam logic [PIN_CNT-1:0] PINS_IDLE = 5'b01001;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST;
        else if (g == 0) stg[g] <= d;
        else stg[g] <= stg[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
  parameter int unsigned W   = 16,
  parameter logic [W-1:0] MID = 16'h8000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_frame_n,
  input  logic         s_sck,
  input  logic         s_din,
  output logic [W-1:0] sreg,
  output logic         full,
  output logic         frame_end,
  output logic         ser_out
);
  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(W);

  logic          prev_frame_n, prev_sck;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  sreg_d;
  logic          sck_fall, shift_en;

  assign sck_fall  = prev_sck & ~s_sck;
  assign shift_en  = sck_fall & ~s_frame_n;
  assign frame_end = s_frame_n & ~prev_frame_n;
  assign full      = (cnt_q == CNT_FULL);
  assign ser_out   = sreg[W-1];

  always_comb begin
    sreg_d = sreg;
    cnt_d  = cnt_q;
    if (shift_en) sreg_d = {sreg[W-2:0], s_din};
    if (s_frame_n) cnt_d = '0;
    else if (shift_en && !full) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg         <= MID;
      cnt_q        <= '0;
      prev_frame_n <= 1'b1;
      prev_sck     <= 1'b0;
    end else begin
      sreg         <= sreg_d;
      cnt_q        <= cnt_d;
      prev_frame_n <= s_frame_n;
      prev_sck     <= s_sck;
    end
  end

  // R2: nothing shifts while the frame is closed
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s_frame_n |=> $stable(sreg));
  // R2: a shift moves the next-lower bit onto the output
  p_shift_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en) |=> (ser_out == $past(sreg[W-2])));
  // R3: the edge count never passes one word
  p_cnt_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
endmodule

// File: rtl/sdac_update.sv
module sdac_update #(
  parameter int unsigned W   = 16,
  parameter logic [W-1:0] MID = 16'h8000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_end,
  input  logic         full,
  input  logic         s_frame_n,
  input  logic         s_load_n,
  input  logic [W-1:0] sreg,
  output logic [W-1:0] dac_code
);
  logic [W-1:0] hold_q, hold_d, dac_d;
  logic         take_word, sync_upd, async_upd;

  assign take_word = frame_end & full;
  assign sync_upd  = take_word & ~s_load_n;
  assign async_upd = s_frame_n & ~frame_end & ~s_load_n;

  always_comb begin
    hold_d = hold_q;
    dac_d  = dac_code;
    if (take_word) hold_d = sreg;
    if (sync_upd) dac_d = sreg;
    else if (async_upd) dac_d = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= MID;
      dac_code <= MID;
    end else begin
      hold_q   <= hold_d;
      dac_code <= dac_d;
    end
  end

  // R4: short frame leaves the holding register alone
  p_partial_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !full) |=> $stable(hold_q));
  // R5: asynchronous load copies the holding word
  p_async_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_frame_n && !frame_end && !s_load_n) |=> (dac_code == $past(hold_q)));
  // R6: synchronous load lands with the new holding word
  p_sync_land_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && full && !s_load_n) |=> (dac_code == hold_q));
  // R7: code stays put while load is released
  p_load_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s_load_n |=> $stable(dac_code));
endmodule

// File: rtl/sdac_load_if.sv
module sdac_load_if #(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              load_n,
  input  logic              pwr_dn,
  output logic              ser_out,
  output logic [WORD_W-1:0] dac_code,
  output logic              dac_off
);
  import sdac_pkg::*;
  localparam logic [WORD_W-1:0] MID = {1'b1, {(WORD_W-1){1'b0}}};

  logic [PIN_CNT-1:0] raw_pins, s_pins;
  logic [WORD_W-1:0]  sreg;
  logic               full, frame_end, pd_q;

  assign raw_pins[P_FRAME] = frame_n;
  assign raw_pins[P_SCK]   = ser_clk;
  assign raw_pins[P_DIN]   = ser_din;
  assign raw_pins[P_LOAD]  = load_n;
  assign raw_pins[P_PD]    = pwr_dn;

  sdac_sync #(.W(PIN_CNT), .STAGES(SYNC_STAGES), .RST(PINS_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_pins), .q(s_pins)
  );

  sdac_shifter #(.W(WORD_W), .MID(MID)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .s_frame_n(s_pins[P_FRAME]), .s_sck(s_pins[P_SCK]), .s_din(s_pins[P_DIN]),
    .sreg(sreg), .full(full), .frame_end(frame_end), .ser_out(ser_out)
  );

  sdac_update #(.W(WORD_W), .MID(MID)) u_upd (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .full(full),
    .s_frame_n(s_pins[P_FRAME]), .s_load_n(s_pins[P_LOAD]),
    .sreg(sreg), .dac_code(dac_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd_q <= 1'b0;
    else        pd_q <= s_pins[P_PD];
  end
  assign dac_off = pd_q;

  // R9: the flag follows the synchronized request one cycle later
  p_pd_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_pins[P_PD]) |=> dac_off);
endmodule

// File: tb/sdac_load_if_tb_top.sv
`timescale 1ns/1ps
module sdac_load_if_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic frame_n, ser_clk, ser_din, load_n, pwr_dn;
  logic ser_out, dac_off;
  logic [15:0] dac_code;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sdac_load_if dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ser_clk(ser_clk),
    .ser_din(ser_din), .load_n(load_n), .pwr_dn(pwr_dn),
    .ser_out(ser_out), .dac_code(dac_code), .dac_off(dac_off)
  );

  // Reference model: pin history delayed by the synchronizer depth
  localparam logic [4:0] IDLE = 5'b01001; // {pd, load_n, din, sck, frame_n}
  logic [4:0] hist [$];
  logic [15:0] m_sh, m_hold, m_dac;
  int m_edges;
  logic m_pd;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {IDLE, IDLE, IDLE};
      m_sh = 16'h8000; m_hold = 16'h8000; m_dac = 16'h8000;
      m_edges = 0; m_pd = 1'b0;
    end else begin
      logic [4:0] cur, prv;
      bit fall, fend;
      hist.push_back({pwr_dn, load_n, ser_din, ser_clk, frame_n});
      if (hist.size() > 8) void'(hist.pop_front());
      cur = hist[hist.size()-3];
      prv = hist[hist.size()-4];
      fall = prv[1] && !cur[1];
      fend = cur[0] && !prv[0];
      if (fend && m_edges >= 16) begin
        m_hold = m_sh;
        if (!cur[3]) m_dac = m_sh;
      end else if (cur[0] && !fend && !cur[3]) begin
        m_dac = m_hold;
      end
      if (!cur[0] && fall) begin
        m_sh = {m_sh[14:0], cur[2]};
        m_edges++;
      end
      if (cur[0]) m_edges = 0;
      m_pd = cur[4];
    end
  end

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      n_chk++;
      if (dac_code !== m_dac) begin
        n_err++;
        $display("FAIL R5/R6 model dac_code act=%h exp=%h", dac_code, m_dac);
      end
      n_chk++;
      if (ser_out !== m_sh[15]) begin
        n_err++;
        $display("FAIL R2 model ser_out act=%b exp=%b", ser_out, m_sh[15]);
      end
      n_chk++;
      if (dac_off !== m_pd) begin
        n_err++;
        $display("FAIL R10 model dac_off act=%b exp=%b", dac_off, m_pd);
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_din = v[i]; ser_clk = 1'b1; wclk(2);
      ser_clk = 1'b0; wclk(2);
    end
  endtask

  task automatic frame(input logic [15:0] w, input int n);
    frame_n = 1'b0; wclk(2);
    shift_bits({16'h0, w}, n);
    wclk(2); frame_n = 1'b1; wclk(6);
  endtask

  task automatic pulse_load();
    load_n = 1'b0; wclk(3); load_n = 1'b1; wclk(5);
  endtask

  initial begin
    rst_n = 1'b0; frame_n = 1'b1; ser_clk = 1'b0; ser_din = 1'b0;
    load_n = 1'b1; pwr_dn = 1'b0;
    wclk(4); rst_n = 1'b1; wclk(2);
    chk("R1 dac_code reset", dac_code, 16'h8000);
    chk("R1 ser_out reset", {15'h0, ser_out}, 16'h1);
    chk("R1 dac_off reset", {15'h0, dac_off}, 16'h0);

    // clock edges with frame closed do nothing
    shift_bits(32'h0, 4); wclk(4);
    chk("R2 no shift outside frame", {15'h0, ser_out}, 16'h1);

    frame(16'h1234, 16);
    chk("R7 load high keeps code", dac_code, 16'h8000);
    pulse_load();
    chk("R3 R5 async load of word", dac_code, 16'h1234);

    frame(16'hFFFF, 10);
    pulse_load();
    chk("R4 partial frame discarded", dac_code, 16'h1234);
    frame(16'h0, 0);
    pulse_load();
    chk("R4 empty frame discarded", dac_code, 16'h1234);

    load_n = 1'b0; wclk(4);
    frame(16'hA5C3, 16);
    chk("R6 sync update on frame close", dac_code, 16'hA5C3);
    frame(16'h0000, 16);
    chk("R3 R6 all-zero code", dac_code, 16'h0000);
    frame(16'hFFFF, 16);
    chk("R3 R6 all-ones code", dac_code, 16'hFFFF);
    load_n = 1'b1; wclk(4);

    // daisy chain: 32 edges in one frame
    frame_n = 1'b0; wclk(2);
    shift_bits({16'h0, 16'h6EAD}, 16); wclk(4);
    chk("R8 ser_out after 16 shifts", {15'h0, ser_out}, 16'h0);
    shift_bits(32'h1, 1); wclk(4);
    chk("R8 ser_out after 17 shifts", {15'h0, ser_out}, 16'h1);
    shift_bits({16'h0, 16'h3EEF}, 15);
    wclk(2); frame_n = 1'b1; wclk(6);
    chk("R7 chained frame no load", dac_code, 16'hFFFF);
    pulse_load();
    chk("R8 last word kept", dac_code, 16'hBEEF);

    pwr_dn = 1'b1; wclk(1);
    chk("R10 dac_off not yet", {15'h0, dac_off}, 16'h0);
    wclk(3);
    chk("R9 dac_off set", {15'h0, dac_off}, 16'h1);
    chk("R9 code kept in power-down", dac_code, 16'hBEEF);
    frame(16'h0F0F, 16); pulse_load();
    chk("R9 serial path active in power-down", dac_code, 16'h0F0F);
    pwr_dn = 1'b0; wclk(4);
    chk("R9 dac_off cleared", {15'h0, dac_off}, 16'h0);

    wclk(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule